// File: doc/BRIEF.md
# UART Receive Character FIFO

This block holds characters on their way from a UART's receive line logic to the register read port. Each entry is 11 bits wide: eight data bits plus three error flags, with the top bit marking a line break. The line side offers words on a valid/ready push port. A separate break-event input inserts a break word. The register side sees the head entry at all times and removes it with a single-cycle pop strobe. The block reports empty and full, and it drives a receive interrupt request that follows a trigger level.

The data interface follows valid/ready rules. A word moves when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` depends only on the stored count, the FIFO-enable input and the break input, never on `in_valid` or `pop`. When the FIFO is enabled, the storage holds up to 16 entries. When it is disabled, the block acts as a one-character holding register and accepts a word only while it is empty. The producer must keep its word valid until it is accepted. A break event that arrives while there is no room is lost.

The trigger level is fixed at one entry, so the interrupt marks a non-empty FIFO. In a cycle that has both a push and a pop, the pop is applied first and the push second.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `rx_irq` is 0 and `in_ready` is 1.
- R2: Entries leave in the order they were accepted. `rd_data` always shows the entry at the read position. A pop with at least one entry stored advances the read position, wrapping from slot 15 back to slot 0.
- R3: With `fifo_en` = 1, `in_ready` is high while fewer than 16 entries are stored. `full` rises when a push brings the count to 16 and drops on any pop. A word offered while the FIFO is full is not stored.
- R4: With `fifo_en` = 0, `in_ready` is high only while no entry is stored, so at most one character is held. Entries already stored when the input goes low are still delivered in order.
- R5: A `brk_evt` pulse pushes the word 11'h400 (bit 10 set, bits 9:0 zero) whenever there is room. During `brk_evt`, `in_ready` is 0, so a simultaneous `in_valid` word is not taken.
- R6: `empty` drops on any accepted push. It rises when a pop leaves zero entries.
- R7: A pop while empty leaves the read position and the count unchanged. `rd_data` keeps showing the same slot, which holds the older contents of that slot (zero after reset).
- R8: `rx_irq` rises when a push brings the count to the trigger level (1). It falls when a pop brings the count to the trigger level minus one.
- R9: In a cycle with both a pop and an accepted push, the pop is applied first. With one or more entries stored, the count, `empty` and `rx_irq` end unchanged. With none stored, the push alone takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 16-entry FIFO, 0: single holding entry |
| in_valid | input | 1 | Push word valid |
| in_data | input | 11 | Received character with error flags |
| in_ready | output | 1 | Room for a push this cycle |
| brk_evt | input | 1 | Line-break event, pushes 11'h400 |
| pop | input | 1 | Remove the head entry |
| rd_data | output | 11 | Entry at the read position |
| empty | output | 1 | No entries stored |
| full | output | 1 | 16 entries stored |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench fills the FIFO to every level from 0 to 17 and drains it, so each level and each wrap point is crossed. A design with a wrong pointer wrap would return data out of order. A design that accepts a 17th word would corrupt the oldest entry. Pops issued while empty catch a design that moves the pointer: it would show a different slot afterwards and lose alignment with later data. Combined pop and push at every count, single-entry mode, and break collisions with valid data each target a bad ordering or a bad ready decision. Such a design would either duplicate entries, lose them, or leave the interrupt low while data is still waiting.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // width of one stored character: 8 data bits + 3 error flags
  localparam int unsigned CHAR_W = 11;
  // break marker sits on the top bit, data bits zero
  localparam logic [CHAR_W-1:0] BREAK_WORD = CHAR_W'(1) << (CHAR_W - 1);
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DW    = 11,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [DW-1:0] wr_word,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[s] <= '0;
      else if (wr_en && wr_idx == PW'(s))
        slot_q[s] <= wr_word;
    end
  end

  assign rd_word = slot_q[rd_idx];
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TRIG  = 1,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          push_req,
  input  logic          pop,
  output logic          room,
  output logic          push_ok,
  output logic [PW-1:0] rd_idx,
  output logic [PW-1:0] wr_idx,
  output logic          empty,
  output logic          full,
  output logic          irq
);
  logic [CW-1:0] cnt_q, cnt_mid, cnt_d;
  logic [PW-1:0] rd_q, rd_d;
  logic          empty_q, full_q, irq_q;
  logic          empty_d, full_d, irq_d;
  logic          pop_take;
  logic [CW:0]   wsum;

  // room decision uses only stored state, so ready never waits on valid
  assign room     = fifo_en ? (cnt_q < CW'(DEPTH)) : (cnt_q == '0);
  assign push_ok  = push_req && room;
  assign pop_take = pop && (cnt_q != '0);

  // pop applied first, push second
  assign cnt_mid = cnt_q - {{(CW-1){1'b0}}, pop_take};
  assign cnt_d   = cnt_mid + {{(CW-1){1'b0}}, push_ok};

  assign rd_d = !pop_take ? rd_q :
                (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);

  assign wsum   = (CW+1)'(rd_q) + (CW+1)'(cnt_q);
  assign wr_idx = (wsum >= (CW+1)'(DEPTH)) ? PW'(wsum - (CW+1)'(DEPTH)) : PW'(wsum);

  always_comb begin
    empty_d = empty_q;
    full_d  = full_q;
    irq_d   = irq_q;
    if (pop) begin
      full_d = 1'b0;
      if (cnt_mid == '0) empty_d = 1'b1;
      if (cnt_mid == CW'(TRIG - 1)) irq_d = 1'b0;
    end
    if (push_ok) begin
      empty_d = 1'b0;
      if (cnt_d == CW'(DEPTH)) full_d = 1'b1;
      if (cnt_d == CW'(TRIG)) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rd_q    <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rd_q    <= rd_d;
      empty_q <= empty_d;
      full_q  <= full_d;
      irq_q   <= irq_d;
    end
  end

  assign rd_idx = rd_q;
  assign empty  = empty_q;
  assign full   = full_q;
  assign irq    = irq_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R6
  empty_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q == (cnt_q == '0));
  // R3
  full_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_q == (cnt_q == CW'(DEPTH)));
  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (cnt_q >= CW'(TRIG)));
  // R7
  stale_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt_q == '0) |=> $stable(rd_q));
  // R4
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && cnt_q != '0) |-> !room);
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TRIG  = 1,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              brk_evt,
  input  logic              pop,
  output logic [CHAR_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              rx_irq
);
  logic              room, push_ok;
  logic [PW-1:0]     rd_idx, wr_idx;
  logic [CHAR_W-1:0] push_word;

  // break wins over a line word offered in the same cycle
  assign push_word = brk_evt ? BREAK_WORD : in_data;
  assign in_ready  = room && !brk_evt;

  rxf_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .push_req(in_valid || brk_evt), .pop(pop),
    .room(room), .push_ok(push_ok),
    .rd_idx(rd_idx), .wr_idx(wr_idx),
    .empty(empty), .full(full), .irq(rx_irq)
  );

  rxf_store #(.DW(CHAR_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_ok), .wr_idx(wr_idx), .wr_word(push_word),
    .rd_idx(rd_idx), .rd_word(rd_data)
  );

  // R5
  brk_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> !in_ready);
endmodule

// File: tb/rx_char_fifo_test.sv
module rx_char_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b1;
  logic        in_valid = 1'b0;
  logic [10:0] in_data = '0;
  logic        brk_evt = 1'b0;
  logic        pop = 1'b0;
  logic        in_ready, empty, full, rx_irq;
  logic [10:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [10:0] mmem [16];
  int mh = 0;
  int mc = 0;

  always #2 clk = ~clk;

  rx_char_fifo uut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .brk_evt(brk_evt), .pop(pop), .rd_data(rd_data),
    .empty(empty), .full(full), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [10:0] d, input bit b, input bit p, input bit en);
    bit sp;
    logic [10:0] er;
    @(negedge clk);
    in_valid = v; in_data = d; brk_evt = b; pop = p; fifo_en = en;
    #1;
    sp = en ? (mc < 16) : (mc == 0);
    chk(in_ready == (sp && !b), en ? "R3 ready" : "R4 ready", in_ready, sp && !b);
    if (p) begin
      er = mmem[mh];
      chk(rd_data == er, mc == 0 ? "R7 stale head" : (er == 11'h400 ? "R5 break word" : "R2 order"),
          rd_data, er);
    end
    if (p && mc > 0) begin mc--; mh = (mh + 1) % 16; end
    if ((v || b) && sp) begin mmem[(mh + mc) % 16] = b ? 11'h400 : d; mc++; end
    @(posedge clk); #1;
    chk(empty == (mc == 0), "R6 empty", empty, mc == 0);
    chk(full == (mc == 16), "R3 full", full, mc == 16);
    chk(rx_irq == (mc >= 1), "R8 irq", rx_irq, mc >= 1);
    in_valid = 1'b0; brk_evt = 1'b0; pop = 1'b0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mmem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(rx_irq == 1'b0, "R1 irq", rx_irq, 0);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    rst_n = 1'b1;

    // R7 pop right after reset: slot zero content
    step(0, '0, 0, 1, 1);

    // R2 R3 R5: fill to every level 0..17, then drain plus one extra pop
    for (int n = 0; n <= 17; n++) begin
      for (int k = 0; k < n; k++)
        step(1, 11'((n * 53 + k * 7) & 11'h3ff), (k % 5) == 4, 0, 1);
      for (int k = 0; k <= n; k++) step(0, '0, 0, 1, 1);
    end

    // R9 simultaneous pop and push at every count
    for (int n = 0; n <= 16; n++) begin
      for (int k = 0; k < n; k++) step(1, 11'(k + 16 * n), 0, 0, 1);
      step(1, 11'h2aa ^ 11'(n), 0, 1, 1);
      chk(empty == 1'b0 && rx_irq == 1'b1, "R9 pop+push", {empty, rx_irq}, 2'b01);
      for (int k = 0; k <= n + 1; k++) step(0, '0, 0, 1, 1);
    end

    // R4 single entry mode
    step(1, 11'h0a5, 0, 0, 0);
    step(1, 11'h05a, 0, 0, 0);
    step(1, 11'h033, 0, 1, 0);
    step(0, '0, 0, 1, 0);
    step(0, '0, 0, 1, 0);
    // R4 leftover entries after disabling
    for (int k = 0; k < 3; k++) step(1, 11'(k + 11'h100), 0, 0, 1);
    step(1, 11'h1ff, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(0, '0, 0, 1, 0);

    // R5 break collides with valid word, and break into full FIFO
    step(1, 11'h155, 1, 0, 1);
    step(0, '0, 0, 1, 1);
    for (int k = 0; k < 16; k++) step(1, 11'(k), 0, 0, 1);
    step(0, '0, 1, 0, 1);
    for (int k = 0; k < 17; k++) step(0, '0, 0, 1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule